// File: doc/BRIEF.md
# Banked GPIO Register Block with Masked Writes

This block holds the control state for one bank of general-purpose pins, arranged as four ports of eight pins. Each port has three writable control registers: a GPIO-ownership register that hands the pin to this block, a drive-enable register and a drive-value register. A fourth register per port is read-only and returns the synchronised pad levels. All of them sit on a simple word-addressed bus. Writes land on the clock edge that accepts them. Read data is registered and appears on the next cycle.

The three control registers are also reachable through a second address window, the masked alias. A write there updates only the pins selected by the upper byte of the data word, so software can change one pin without reading the register first. The pad side is three flat vectors: drive value, drive enable and the raw pad input. The raw pad input passes through a two-flop synchroniser.

Top module: `gpio_bank`

## Requirements
- R1: While rst_ni is low, all ownership, drive-enable and drive-value bits, both synchroniser stages and rdata_o are 0, so pad_oe_o and pad_out_o are 0.
- R2: Word addresses 0x00+p, 0x04+p and 0x08+p (p = port 0..3) are the ownership, drive-enable and drive-value registers of port p. A write there loads wdata_i[7:0]. Data bit i belongs to pin p*8+i of the flat pad vectors.
- R3: Word addresses 0x20+p, 0x24+p and 0x28+p are the masked aliases of the same registers. A write there sets bit i to wdata_i[i] when wdata_i[8+i] is 1, and leaves bit i unchanged when wdata_i[8+i] is 0.
- R4: pad_oe_o[n] is 1 only when both the ownership bit and the drive-enable bit of pin n are 1. pad_out_o[n] equals the drive-value bit when pad_oe_o[n] is 1, and is 0 otherwise.
- R5: A read of word address 0x0C+p returns, in bits [7:0], pad_in_i[p*8+7:p*8] as sampled by two synchroniser flops. A pad change set up before edge E0 is returned by a read accepted on edge E0+2 or later. Reads accepted on E0 or E0+1 still return the old level.
- R6: rdata_o changes only on an edge that accepts a read (req_i=1, we_i=0). Bits above [7:0] always read 0.
- R7: A read of a masked alias returns the plain register value in bits [7:0].
- R8: Writes to the input words 0x0C..0x0F change no register.
- R9: Any other address reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data; [15:8] mask and [7:0] values for masked aliases |
| rdata_o | output | 32 | Registered read data, valid the cycle after the read |
| pad_in_i | input | 32 | Raw pad levels, asynchronous |
| pad_out_o | output | 32 | Pad drive value |
| pad_oe_o | output | 32 | Pad drive enable |

## Verification
A wrong bit in an ownership, drive-enable or drive-value register shows on pad_oe_o or pad_out_o one cycle after the write that caused it, provided the pin is both owned and enabled. Otherwise it stays hidden until a read of the register or of its masked alias brings it out on rdata_o the following cycle. A masked write that disturbs unselected bits is caught in the same way, by comparing each port's register against the reference after every write. A synchroniser with the wrong depth is exposed by back-to-back reads straddling a pad change, because the cycle on which the new level first appears moves by one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    KIND_CFG = 2'd0,
    KIND_OE  = 2'd1,
    KIND_OUT = 2'd2,
    KIND_IN  = 2'd3
  } reg_kind_e;

  localparam int unsigned WIN_PLAIN  = 0;
  localparam int unsigned WIN_MASKED = 2;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NPORT  = 4,
  localparam int unsigned PORT_W  = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int unsigned WIN_LSB = PORT_W + 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              masked_o,
  output reg_kind_e         kind_o,
  output logic [PORT_W-1:0] port_o
);
  logic [ADDR_W-WIN_LSB-1:0] win;
  logic                      port_ok;

  assign win     = addr_i[ADDR_W-1:WIN_LSB];
  assign kind_o  = reg_kind_e'(addr_i[WIN_LSB-1:PORT_W]);
  assign port_o  = addr_i[PORT_W-1:0];
  assign port_ok = (32'(port_o) < NPORT);

  always_comb begin
    masked_o = 1'b0;
    hit_o    = 1'b0;
    if (32'(win) == WIN_PLAIN) begin
      hit_o = port_ok;
    end else if (32'(win) == WIN_MASKED && kind_o != KIND_IN) begin
      hit_o    = port_ok;
      masked_o = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PIN_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               masked_i,
  input  reg_kind_e          kind_i,
  input  logic [2*PIN_W-1:0] wdata_i,
  output logic [PIN_W-1:0]   cfg_o,
  output logic [PIN_W-1:0]   oe_o,
  output logic [PIN_W-1:0]   out_o
);
  logic [PIN_W-1:0] sel_mask, new_val;

  // plain write selects every bit
  assign sel_mask = masked_i ? wdata_i[2*PIN_W-1:PIN_W] : '1;
  assign new_val  = wdata_i[PIN_W-1:0];

  function automatic logic [PIN_W-1:0] merge(logic [PIN_W-1:0] cur,
                                             logic [PIN_W-1:0] m,
                                             logic [PIN_W-1:0] v);
    return (cur & ~m) | (v & m);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      oe_o  <= '0;
      out_o <= '0;
    end else if (wr_en_i) begin
      unique case (kind_i)
        KIND_CFG: cfg_o <= merge(cfg_o, sel_mask, new_val);
        KIND_OE:  oe_o  <= merge(oe_o, sel_mask, new_val);
        KIND_OUT: out_o <= merge(out_o, sel_mask, new_val);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned NPIN   = NPORT * PIN_W,
  localparam int unsigned PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   pad_oe_o
);
  logic              hit, masked;
  reg_kind_e         kind;
  logic [PORT_W-1:0] port;
  logic [NPIN-1:0]   cfg_q, oe_q, out_q, in_sync;
  logic [PIN_W-1:0]  rd_sel;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .NPORT(NPORT)) u_dec (
    .addr_i   (addr_i),
    .hit_o    (hit),
    .masked_o (masked),
    .kind_o   (kind),
    .port_o   (port)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic wr_en;
    assign wr_en = req_i && we_i && hit && kind != KIND_IN && 32'(port) == p;

    gpio_port_regs #(.PIN_W(PIN_W)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en),
      .masked_i (masked),
      .kind_i   (kind),
      .wdata_i  (wdata_i[2*PIN_W-1:0]),
      .cfg_o    (cfg_q[p*PIN_W +: PIN_W]),
      .oe_o     (oe_q[p*PIN_W +: PIN_W]),
      .out_o    (out_q[p*PIN_W +: PIN_W])
    );

    assign pad_oe_o[p*PIN_W +: PIN_W]  = cfg_q[p*PIN_W +: PIN_W] & oe_q[p*PIN_W +: PIN_W];
    assign pad_out_o[p*PIN_W +: PIN_W] = pad_oe_o[p*PIN_W +: PIN_W] & out_q[p*PIN_W +: PIN_W];
  end

  gpio_in_sync #(.WIDTH(NPIN), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (in_sync)
  );

  always_comb begin
    unique case (kind)
      KIND_CFG: rd_sel = cfg_q[port*PIN_W +: PIN_W];
      KIND_OE:  rd_sel = oe_q[port*PIN_W +: PIN_W];
      KIND_OUT: rd_sel = out_q[port*PIN_W +: PIN_W];
      default:  rd_sel = in_sync[port*PIN_W +: PIN_W];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (req_i && !we_i) rdata_o <= hit ? DATA_W'(rd_sel) : '0;
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NPORT  = 4,
  parameter int unsigned PIN_W  = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned NPIN   = NPORT * PIN_W,
  localparam int unsigned PORT_W = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NPIN-1:0]   pad_out_o,
  input logic [NPIN-1:0]   pad_oe_o,
  input logic [NPIN-1:0]   cfg_q,
  input logic [NPIN-1:0]   oe_q,
  input logic [NPIN-1:0]   out_q
);
  logic wr_input;
  assign wr_input = req_i && we_i && addr_i[ADDR_W-1:PORT_W+2] == '0
                    && addr_i[PORT_W+1:PORT_W] == 2'd3;

  assert_rst_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (cfg_q == '0 && oe_q == '0 && out_q == '0));

  assert_pad_gating_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~cfg_q) == '0) && ((pad_out_o & ~pad_oe_o) == '0));

  assert_rdata_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

  assert_input_write_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_input |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)));

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(p);
    localparam logic [ADDR_W-1:0] OUTM_A = ADDR_W'((2 << (PORT_W + 2)) | (2 << PORT_W) | p);

    assert_plain_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == CFG_A) |=> cfg_q[p*PIN_W +: PIN_W] == $past(wdata_i[PIN_W-1:0]));

    assert_masked_merge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == OUTM_A) |=>
        (((out_q[p*PIN_W +: PIN_W] ^ $past(out_q[p*PIN_W +: PIN_W]))
          & ~$past(wdata_i[2*PIN_W-1:PIN_W])) == '0)
        && (((out_q[p*PIN_W +: PIN_W] ^ $past(wdata_i[PIN_W-1:0]))
          & $past(wdata_i[2*PIN_W-1:PIN_W])) == '0));
  end
endmodule

bind gpio_bank gpio_bank_chk #(
  .NPORT(NPORT), .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o),
  .cfg_q     (cfg_q),
  .oe_q      (oe_q),
  .out_q     (out_q)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pad_in_i = '0;
  logic [31:0] pad_out_o, pad_oe_o;

  int total = 0, fails = 0;
  bit done = 0;

  gpio_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pad_in_i(pad_in_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model
  int cfg_m[4], oe_m[4], out_m[4];
  int s1_m, s2_m, rd_m;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < 4; p++) begin cfg_m[p] = 0; oe_m[p] = 0; out_m[p] = 0; end
      s1_m = 0; s2_m = 0; rd_m = 0;
    end else begin
      int win, k, p, val, msk, cur;
      win = int'(addr_i) >> 4; k = (int'(addr_i) >> 2) & 3; p = int'(addr_i) & 3;
      if (req_i && !we_i) begin
        if (win == 0 || (win == 2 && k != 3)) begin
          case (k)
            0: rd_m = cfg_m[p];
            1: rd_m = oe_m[p];
            2: rd_m = out_m[p];
            default: rd_m = (s2_m >> (8*p)) & 255;
          endcase
        end else rd_m = 0;
      end
      if (req_i && we_i && k != 3 && (win == 0 || win == 2)) begin
        msk = (win == 2) ? int'(wdata_i[15:8]) : 255;
        val = int'(wdata_i[7:0]);
        cur = (k == 0) ? cfg_m[p] : (k == 1) ? oe_m[p] : out_m[p];
        cur = (cur & ~msk & 255) | (val & msk);
        if (k == 0) cfg_m[p] = cur; else if (k == 1) oe_m[p] = cur; else out_m[p] = cur;
      end
      s2_m = s1_m;
      s1_m = int'(pad_in_i);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (rst_ni && !done) begin
    logic [31:0] eoe, eout;
    for (int p = 0; p < 4; p++) begin
      eoe[p*8 +: 8]  = 8'(cfg_m[p] & oe_m[p]);
      eout[p*8 +: 8] = 8'(cfg_m[p] & oe_m[p] & out_m[p]);
    end
    chk("R4 pad_oe", pad_oe_o, eoe);
    chk("R4 pad_out", pad_out_o, eout);
    chk("R6 rdata", rdata_o, 32'(rd_m));
  end

  task automatic bus(bit w, logic [5:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = w; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    bus(0, a, 0);
    chk(tag, rdata_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 pad_oe in reset", pad_oe_o, 0);
    chk("R1 rdata in reset", rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int p = 0; p < 4; p++) begin
      rd(6'(p), 0, "R1 cfg reset");
      rd(6'(8 + p), 0, "R1 out reset");
    end
    rd(6'h0C, 0, "R1 sync reset");

    bus(1, 6'h00, 32'hFFFF_00A5);
    rd(6'h00, 32'hA5, "R2 plain write ignores upper bits");
    bus(1, 6'h09, 32'h0000_00F0);
    rd(6'h09, 32'hF0, "R2 out port1");
    bus(1, 6'h29, 32'h0000_0F0C);
    rd(6'h09, 32'hFC, "R3 masked merge");
    bus(1, 6'h29, 32'h0000_00FF);
    rd(6'h09, 32'hFC, "R3 empty mask keeps");
    rd(6'h29, 32'hFC, "R7 alias read");
    rd(6'h20, 32'hA5, "R7 cfg alias read");

    bus(1, 6'h02, 32'hFF);
    bus(1, 6'h06, 32'h0F);
    bus(1, 6'h0A, 32'hAA);
    chk("R4 pad_oe port2", pad_oe_o[23:16], 8'h0F);
    chk("R4 pad_out port2", pad_out_o[23:16], 8'h0A);
    bus(1, 6'h22, 32'h0100);
    chk("R4 ownership cleared bit0", pad_oe_o[23:16], 8'h0E);

    bus(1, 6'h0C, 32'hFFFF_FFFF);
    bus(1, 6'h2C, 32'hFFFF_FFFF);
    rd(6'h00, 32'hA5, "R8 cfg kept");
    rd(6'h09, 32'hFC, "R8 out kept");
    bus(1, 6'h3F, 32'hFFFF_FFFF);
    bus(1, 6'h10, 32'hFFFF_FFFF);
    rd(6'h3F, 0, "R9 unmapped read");
    rd(6'h2C, 0, "R9 masked input alias read");
    rd(6'h00, 32'hA5, "R9 cfg kept");

    pad_in_i = 32'h1234_5678;
    repeat (3) @(negedge clk_i);
    rd(6'h0C, 32'h78, "R5 port0 input");
    rd(6'h0F, 32'h12, "R5 port3 input");
    pad_in_i = 32'h1234_56FF;
    rd(6'h0C, 32'h78, "R5 latency edge0");
    rd(6'h0C, 32'h78, "R5 latency edge1");
    rd(6'h0C, 32'hFF, "R5 latency edge2");

    for (int i = 0; i < 40; i++) begin
      bus(i[0], 6'((i * 7) & 63), 32'((i * 32'h9E37) ^ 32'h5A5A));
      pad_in_i = pad_in_i + 32'h0101_0103;
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule